// File: doc/BRIEF.md
# Time Base, Watchdog and Tone Generator

This block derives three slow timing functions from a 32.768 kHz clock enable (`sys_tick`) that runs on the fast system clock. A single tick chain serves both the time base and the watchdog. Its lower byte divides by 256, and the stage above it selects one of eight square-wave rates from 1 Hz to 128 Hz. The watchdog counts full periods of the selected rate. On the fourth period it sets a flag, and that flag holds until software clears it. A separate small counter makes a complementary buzzer pair at 4 kHz or 2 kHz.

Control arrives as decoded one-cycle commands: an opcode on `cmd_op` qualified by `cmd_stb`, plus a rate code on `cmd_rate` for the rate-select opcode. The active-low `irq_n` output carries the time-base square wave when the timer is on, or the latched watchdog flag. Both are gated by a separate IRQ enable. The timer enable, watchdog enable and IRQ enable are independent of each other.

Top module: `chrono_wdt_tone`

## Requirements
- R1: After reset, irq_n is 1 and tone_p and tone_n are 0. The timer, watchdog, IRQ and tone are all disabled, and the tick chain is zero.
- R2: Opcode 4'h8 loads cmd_rate as the rate code c. The time-base square wave then runs at 2^c Hz, which is a half-period of 2^(14-c) ticks. After reset the code is 7, giving 128 Hz with a half-period of 128 ticks.
- R3: With the timer on (opcode 4'h1) and IRQ on (opcode 4'h7), irq_n is low exactly while the time-base wave is high. The timer is turned off by opcode 4'h0.
- R4: Opcode 4'h4 zeroes the whole tick chain. The wave then starts low and goes high after exactly one half-period of ticks.
- R5: With the watchdog on (opcode 4'h3), the flag sets on the fourth time-base period boundary after the watchdog stage is cleared. When the chain is also zero, this is after 4 x 2^(15-c) ticks. Opcode 4'h2 turns the watchdog off.
- R6: Once set, the watchdog flag holds irq_n low (when IRQ is enabled) until opcode 4'h5 clears the watchdog stage and the flag.
- R7: Opcode 4'h6 disables IRQ, forces irq_n high and clears the watchdog flag. Enabling IRQ again afterwards leaves irq_n high.
- R8: With IRQ disabled, the time-base wave never reaches irq_n. With the watchdog disabled, no flag is ever raised.
- R9: Opcode 4'hA turns on the 4 kHz tone: tone_p toggles every 4 ticks and starts low. Opcode 4'hB selects 2 kHz: tone_p toggles every 8 ticks. While the tone is on, tone_n is the complement of tone_p.
- R10: Opcode 4'h9 turns the tone off, drives both tone outputs low and restarts the tone counter from zero.
- R11: While cmd_stb is low, cmd_op and cmd_rate have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_tick | input | 1 | 32.768 kHz clock enable, one cycle wide |
| cmd_stb | input | 1 | Command strobe |
| cmd_op | input | 4 | Decoded command opcode |
| cmd_rate | input | 3 | Rate code used with opcode 4'h8 |
| irq_n | output | 1 | Active-low time-base / watchdog interrupt |
| tone_p | output | 1 | Buzzer output, true phase |
| tone_n | output | 1 | Buzzer output, complement phase |

## Verification
The time base is run at the default code and at codes 5, 3 and 0, each started from a cleared chain. Measuring the first rising and falling edge of the wave at each code separates a wrong bit select from a wrong clear or a wrong polarity. The watchdog is run twice: once from a fully aligned chain, and once from a mid-period chain after a clear. This shows whether the stage counts period boundaries rather than raw ticks, and whether the flag latches and releases on the right commands. The tone is driven once with a tick on every cycle and once with a tick every third cycle. The toggle counts then separate the two dividers from dependence on the system clock, and a short run across an off/on cycle shows whether the counter restarts.

// File: rtl/chrono_pkg.sv
package chrono_pkg;

  typedef enum logic [3:0] {
    OP_TB_OFF   = 4'h0,
    OP_TB_ON    = 4'h1,
    OP_WD_OFF   = 4'h2,
    OP_WD_ON    = 4'h3,
    OP_TB_CLR   = 4'h4,
    OP_WD_CLR   = 4'h5,
    OP_IRQ_OFF  = 4'h6,
    OP_IRQ_ON   = 4'h7,
    OP_RATE     = 4'h8,
    OP_TONE_OFF = 4'h9,
    OP_TONE_HI  = 4'hA,
    OP_TONE_LO  = 4'hB
  } op_e;

  typedef struct packed {
    logic tb_en;
    logic wd_en;
    logic irq_en;
    logic tone_en;
    logic tone_hi;
  } ctl_t;

endpackage

// File: rtl/chrono_ctrl.sv
module chrono_ctrl
  import chrono_pkg::*;
#(
  parameter int RATE_W = 3,
  parameter int DEFAULT_RATE = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_stb,
  input  logic [3:0]        cmd_op,
  input  logic [RATE_W-1:0] cmd_rate,
  output ctl_t              ctl,
  output logic [RATE_W-1:0] rate_sel,
  output logic              chain_clr,
  output logic              wd_clr,
  output logic              irq_drop
);

  op_e op;
  assign op = op_e'(cmd_op);

  // One-cycle strobes consumed by neighbouring stages
  assign chain_clr = cmd_stb && (op == OP_TB_CLR);
  assign wd_clr    = cmd_stb && (op == OP_WD_CLR);
  assign irq_drop  = cmd_stb && (op == OP_IRQ_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl      <= '0;
      rate_sel <= RATE_W'(DEFAULT_RATE);
    end else if (cmd_stb) begin
      case (op)
        OP_TB_OFF:   ctl.tb_en   <= 1'b0;
        OP_TB_ON:    ctl.tb_en   <= 1'b1;
        OP_WD_OFF:   ctl.wd_en   <= 1'b0;
        OP_WD_ON:    ctl.wd_en   <= 1'b1;
        OP_IRQ_OFF:  ctl.irq_en  <= 1'b0;
        OP_IRQ_ON:   ctl.irq_en  <= 1'b1;
        OP_RATE:     rate_sel    <= cmd_rate;
        OP_TONE_OFF: ctl.tone_en <= 1'b0;
        OP_TONE_HI: begin
          ctl.tone_en <= 1'b1;
          ctl.tone_hi <= 1'b1;
        end
        OP_TONE_LO: begin
          ctl.tone_en <= 1'b1;
          ctl.tone_hi <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // R11: without a strobe the control state is frozen
  assert_no_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_stb |=> ($stable(ctl) && $stable(rate_sel)))
    else $error("control changed without strobe");

endmodule

// File: rtl/chrono_chain.sv
module chrono_chain #(
  parameter int PRE_W   = 8,
  parameter int STAGE_W = 7,
  parameter int RATE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              clr,
  input  logic [RATE_W-1:0] rate,
  output logic              wave,
  output logic              period_end
);

  localparam int CHAIN_W = PRE_W + STAGE_W;
  localparam logic [CHAIN_W-1:0] ONE = CHAIN_W'(1);

  logic [CHAIN_W-1:0] chain;
  logic               pre_wrap;

  // Bit of the chain that forms the square wave for rate code r
  function automatic logic wave_bit(input logic [CHAIN_W-1:0] c,
                                    input logic [RATE_W-1:0]  r);
    return c[CHAIN_W - 1 - int'(r)];
  endfunction

  // True when every bit up to and including the wave bit is set
  function automatic logic span_full(input logic [CHAIN_W-1:0] c,
                                     input logic [RATE_W-1:0]  r);
    logic [CHAIN_W-1:0] m;
    m = (ONE << (CHAIN_W - int'(r))) - ONE;
    return (c & m) == m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chain <= '0;
    else if (clr)     chain <= '0;
    else if (tick)    chain <= chain + ONE;
  end

  assign pre_wrap   = tick && (&chain[PRE_W-1:0]);
  assign wave       = wave_bit(chain, rate);
  assign period_end = tick && span_full(chain, rate);

  // R2: the shared prescaler byte wraps to zero after its carry
  assert_prescale_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_wrap && !clr) |=> (chain[PRE_W-1:0] == '0))
    else $error("prescaler did not wrap");

  // R4: a clear restarts the wave low
  assert_clear_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !wave)
    else $error("wave high after clear");

  // R2: a period boundary drops the wave unless the rate moved
  assert_period_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && !clr) |=> (!wave || (rate != $past(rate))))
    else $error("wave high after period end");

endmodule

// File: rtl/chrono_wdog.sv
module chrono_wdog #(
  parameter int WD_PERIODS = 4,
  localparam int WD_W = $clog2(WD_PERIODS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic period_end,
  input  logic clr,
  output logic flag
);

  localparam logic [WD_W-1:0] LAST = WD_W'(WD_PERIODS - 1);

  logic [WD_W-1:0] cnt;
  logic            expire;

  assign expire = en && period_end && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (!en) begin
      cnt  <= '0;
    end else if (period_end) begin
      if (expire) begin
        cnt  <= '0;
        flag <= 1'b1;
      end else begin
        cnt  <= cnt + WD_W'(1);
      end
    end
  end

  // R6: the flag stays until a clear
  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag)
    else $error("watchdog flag dropped on its own");

  // R5 / R8: the flag only rises on an enabled period boundary
  assert_flag_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(en && period_end))
    else $error("watchdog flag rose without a boundary");

endmodule

// File: rtl/chrono_tone.sv
module chrono_tone #(
  parameter int TONE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic on,
  input  logic hi,
  output logic tone_p,
  output logic tone_n
);

  localparam int HI_BIT = TONE_W - 2;
  localparam int LO_BIT = TONE_W - 1;

  logic [TONE_W-1:0] cnt;
  logic              phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!on)    cnt <= '0;
    else if (tick)   cnt <= cnt + TONE_W'(1);
  end

  assign phase  = hi ? cnt[HI_BIT] : cnt[LO_BIT];
  assign tone_p = on & phase;
  assign tone_n = on & ~phase;

  // R9: the tone counter only moves on a tick
  assert_tone_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (on && !tick) |=> ($stable(cnt) || !on))
    else $error("tone counter moved without tick");

endmodule

// File: rtl/chrono_wdt_tone.sv
module chrono_wdt_tone
  import chrono_pkg::*;
#(
  parameter int PRE_W      = 8,
  parameter int STAGE_W    = 7,
  parameter int WD_PERIODS = 4,
  parameter int TONE_W     = 4,
  localparam int RATE_W    = $clog2(STAGE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_tick,
  input  logic              cmd_stb,
  input  logic [3:0]        cmd_op,
  input  logic [RATE_W-1:0] cmd_rate,
  output logic              irq_n,
  output logic              tone_p,
  output logic              tone_n
);

  ctl_t              ctl;
  logic [RATE_W-1:0] rate_sel;
  logic              chain_clr;
  logic              wd_clr;
  logic              irq_drop;
  logic              tb_wave;
  logic              period_end;
  logic              wd_flag;

  chrono_ctrl #(
    .RATE_W      (RATE_W),
    .DEFAULT_RATE(STAGE_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_stb  (cmd_stb),
    .cmd_op   (cmd_op),
    .cmd_rate (cmd_rate),
    .ctl      (ctl),
    .rate_sel (rate_sel),
    .chain_clr(chain_clr),
    .wd_clr   (wd_clr),
    .irq_drop (irq_drop)
  );

  chrono_chain #(
    .PRE_W  (PRE_W),
    .STAGE_W(STAGE_W),
    .RATE_W (RATE_W)
  ) u_chain (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sys_tick),
    .clr       (chain_clr),
    .rate      (rate_sel),
    .wave      (tb_wave),
    .period_end(period_end)
  );

  chrono_wdog #(
    .WD_PERIODS(WD_PERIODS)
  ) u_wdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctl.wd_en),
    .period_end(period_end),
    .clr       (wd_clr | irq_drop),
    .flag      (wd_flag)
  );

  chrono_tone #(
    .TONE_W(TONE_W)
  ) u_tone (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (sys_tick),
    .on    (ctl.tone_en),
    .hi    (ctl.tone_hi),
    .tone_p(tone_p),
    .tone_n(tone_n)
  );

  assign irq_n = ~(ctl.irq_en & ((ctl.tb_en & tb_wave) | wd_flag));

  // R7: disabling IRQ releases the line on the next cycle
  assert_irq_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && (cmd_op == 4'(OP_IRQ_OFF))) |=> irq_n)
    else $error("irq_n low after IRQ disable");

  // R9: the buzzer pair is complementary while the tone is on
  assert_tone_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.tone_en |-> (tone_p != tone_n))
    else $error("tone pair not complementary");

  // R10: both buzzer lines rest low when the tone is off
  assert_tone_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.tone_en |-> (!tone_p && !tone_n))
    else $error("tone output active while off");

endmodule

// File: tb/sim_chrono_wdt_tone.sv
module sim_chrono_wdt_tone;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sys_tick = 1'b0;
  logic       cmd_stb = 1'b0;
  logic [3:0] cmd_op = 4'h0;
  logic [2:0] cmd_rate = 3'd0;
  logic       irq_n;
  logic       tone_p;
  logic       tone_n;

  int n_checks = 0;
  int n_fail = 0;
  int tick_gap = 0;
  int gap_cnt = 0;

  chrono_wdt_tone u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .sys_tick(sys_tick),
    .cmd_stb (cmd_stb),
    .cmd_op  (cmd_op),
    .cmd_rate(cmd_rate),
    .irq_n   (irq_n),
    .tone_p  (tone_p),
    .tone_n  (tone_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Tick generator: a tick every tick_gap cycles, none when zero
  always @(negedge clk) begin
    if (tick_gap == 0) begin
      sys_tick = 1'b0;
    end else begin
      sys_tick = (gap_cnt == 0);
      gap_cnt  = (gap_cnt + 1 == tick_gap) ? 0 : gap_cnt + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_gap(input int g);
    tick_gap = g;
    gap_cnt  = 0;
  endtask

  task automatic cmd(input logic [3:0] op, input logic [2:0] rate);
    @(negedge clk);
    cmd_stb  = 1'b1;
    cmd_op   = op;
    cmd_rate = rate;
    @(negedge clk);
    cmd_stb  = 1'b0;
  endtask

  // Wait for n ticks to be consumed, then sample a quarter period later
  task automatic adv_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!sys_tick) @(posedge clk);
    end
    #(CLK_PERIOD/4);
  endtask

  task automatic t_reset();
    check("R1 irq_n", int'(irq_n), 1);
    check("R1 tone_p", int'(tone_p), 0);
    check("R1 tone_n", int'(tone_n), 0);
  endtask

  // Default rate 7: half-period 128 ticks from the zero chain after reset
  task automatic t_default_rate();
    set_gap(0);
    cmd(4'h1, 3'd0);
    cmd(4'h7, 3'd0);
    set_gap(1);
    adv_ticks(127);
    check("R2 default rate before edge", int'(irq_n), 1);
    adv_ticks(1);
    check("R3 default rate wave high", int'(irq_n), 0);
    adv_ticks(128);
    check("R2 default rate wave low", int'(irq_n), 1);
    set_gap(0);
    cmd(4'h6, 3'd0);
    cmd(4'h0, 3'd0);
  endtask

  task automatic t_rate(input int c);
    int half;
    half = 1 << (14 - c);
    set_gap(0);
    cmd(4'h8, 3'(c));
    cmd(4'h4, 3'd0);
    cmd(4'h1, 3'd0);
    cmd(4'h7, 3'd0);
    check("R4 wave low after clear", int'(irq_n), 1);
    set_gap(1);
    adv_ticks(half - 1);
    check("R2 rate first half", int'(irq_n), 1);
    adv_ticks(1);
    check("R4 rise after one half-period", int'(irq_n), 0);
    adv_ticks(half - 1);
    check("R3 rate second half", int'(irq_n), 0);
    adv_ticks(1);
    check("R2 fall after full period", int'(irq_n), 1);
    set_gap(0);
    cmd(4'h6, 3'd0);
    cmd(4'h0, 3'd0);
  endtask

  task automatic t_independent();
    set_gap(0);
    cmd(4'h8, 3'd7);
    cmd(4'h4, 3'd0);
    cmd(4'h1, 3'd0);
    set_gap(1);
    adv_ticks(128);
    check("R8 timer masked without IRQ", int'(irq_n), 1);
    adv_ticks(100);
    check("R8 timer still masked", int'(irq_n), 1);
    set_gap(0);
    cmd(4'h0, 3'd0);
    cmd(4'h7, 3'd0);
    cmd(4'h4, 3'd0);
    cmd(4'h5, 3'd0);
    set_gap(1);
    adv_ticks(2048);
    check("R8 no flag with watchdog off", int'(irq_n), 1);
    set_gap(0);
    cmd(4'h6, 3'd0);
  endtask

  task automatic t_watchdog();
    set_gap(0);
    cmd(4'h8, 3'd7);
    cmd(4'h4, 3'd0);
    cmd(4'h5, 3'd0);
    cmd(4'h3, 3'd0);
    cmd(4'h7, 3'd0);
    set_gap(1);
    adv_ticks(1023);
    check("R5 no flag before fourth boundary", int'(irq_n), 1);
    adv_ticks(1);
    check("R5 flag at fourth boundary", int'(irq_n), 0);
    adv_ticks(300);
    check("R6 flag latched", int'(irq_n), 0);
    set_gap(0);
    cmd(4'h5, 3'd0);
    check("R6 watchdog clear releases", int'(irq_n), 1);
    // chain now at 1324: boundaries after 212, 468, 724, 980 ticks
    set_gap(1);
    adv_ticks(979);
    check("R5 mid-period restart before", int'(irq_n), 1);
    adv_ticks(1);
    check("R5 mid-period restart flag", int'(irq_n), 0);
    set_gap(0);
    cmd(4'h6, 3'd0);
    check("R7 IRQ disable releases", int'(irq_n), 1);
    cmd(4'h7, 3'd0);
    check("R7 flag cleared by IRQ disable", int'(irq_n), 1);
    cmd(4'h2, 3'd0);
    cmd(4'h6, 3'd0);
  endtask

  task automatic t_no_strobe();
    set_gap(0);
    cmd(4'h4, 3'd0);
    @(negedge clk);
    cmd_op = 4'h1;
    @(negedge clk);
    cmd_op = 4'h7;
    @(negedge clk);
    cmd_op = 4'h8;
    cmd_rate = 3'd0;
    @(negedge clk);
    cmd_op = 4'h0;
    set_gap(1);
    adv_ticks(128);
    check("R11 unstrobed ops ignored", int'(irq_n), 1);
    set_gap(0);
    cmd(4'h1, 3'd0);
    cmd(4'h7, 3'd0);
    cmd(4'h4, 3'd0);
    set_gap(1);
    adv_ticks(128);
    check("R11 rate unchanged without strobe", int'(irq_n), 0);
    set_gap(0);
    cmd(4'h6, 3'd0);
    cmd(4'h0, 3'd0);
  endtask

  task automatic count_toggles(input int nticks, input int exp, input string req);
    logic prev;
    int   tog;
    int   bad;
    tog  = 0;
    bad  = 0;
    prev = tone_p;
    for (int i = 0; i < nticks; i++) begin
      adv_ticks(1);
      if (tone_p !== prev) tog++;
      prev = tone_p;
      if (tone_n !== ~tone_p) bad++;
    end
    check(req, tog, exp);
    check("R9 complement", bad, 0);
  endtask

  task automatic t_tone();
    set_gap(0);
    cmd(4'hA, 3'd0);
    check("R9 tone starts low", int'(tone_p), 0);
    check("R9 tone_n starts high", int'(tone_n), 1);
    set_gap(1);
    count_toggles(64, 16, "R9 4 kHz toggles");
    set_gap(0);
    cmd(4'hB, 3'd0);
    set_gap(3);
    count_toggles(64, 8, "R9 2 kHz toggles");
    set_gap(0);
    cmd(4'h9, 3'd0);
    check("R10 tone_p off", int'(tone_p), 0);
    check("R10 tone_n off", int'(tone_n), 0);
    cmd(4'hA, 3'd0);
    set_gap(1);
    adv_ticks(2);
    set_gap(0);
    cmd(4'h9, 3'd0);
    cmd(4'hA, 3'd0);
    set_gap(1);
    adv_ticks(3);
    check("R10 counter restarted", int'(tone_p), 0);
    adv_ticks(1);
    check("R10 first toggle after restart", int'(tone_p), 1);
    set_gap(0);
    cmd(4'h9, 3'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_rate();
    t_rate(5);
    t_rate(3);
    t_rate(0);
    t_independent();
    t_watchdog();
    t_no_strobe();
    t_tone();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule